// File: doc/BRIEF.md
# Link Pulse Burst Generator

This block drives the transmit pulse strobe that an analog line driver turns into link pulses on a twisted pair. In burst mode it sends a fast link pulse burst: a train of clock pulses at a fixed spacing. Between each pair of clock pulses there is a data slot, which carries a pulse when the matching bit of a 16-bit link code word is 1. In single-pulse mode it sends one normal link pulse per repeat period, as used on a link forced to 10 Mb/s. Both modes repeat on the same long schedule.

All timing is given in nanoseconds: pulse width 100 ns, clock-pulse spacing 125 µs, data-pulse offset 62 µs and repeat period 16 ms. The block turns each value into clock cycles from the clock-frequency parameter. The code word and the mode are captured when each burst starts. Dropping the enable lets the pulse in flight finish, then silences the output and rewinds the schedule. A one-cycle done strobe marks the end of the last pulse of each burst.

Top module: `flp_burst_gen`

## Requirements
- R1: While reset is asserted, and right after it is released with enable low, `pulse_out` and `burst_done` are 0.
- R2: Every pulse on `pulse_out` is high for exactly round(PULSE_NS·CLK_HZ/1e9) consecutive cycles, with a minimum of 1.
- R3: In burst mode a burst has WORD_BITS+1 clock pulses, and their rising edges are exactly the clock-pulse spacing in cycles apart.
- R4: For code-word bit k (bit 0 first), a data pulse rises exactly the data offset in cycles after clock pulse k when the bit is 1. When the bit is 0 there is no pulse in that slot. So a burst carries WORD_BITS+1+popcount(word) pulses.
- R5: Successive bursts start exactly the repeat period in cycles apart while enable stays high.
- R6: In single-pulse mode exactly one pulse is sent per repeat period, starting on the same schedule as bursts.
- R7: The code word and the mode are captured in the cycle a burst starts. Changing them later has no effect until the next period.
- R8: Deasserting `en` lets the active pulse complete at full width, then holds `pulse_out` low. The first enabled cycle with no pulse active starts a new burst immediately.
- R9: `burst_done` is high for one cycle, in the cycle `pulse_out` falls at the end of the last clock pulse of a burst (or of the single pulse).
- R10: The pulse width, spacing, offset and period in cycles are each round-to-nearest of the nanosecond parameter times CLK_HZ/1e9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the pulse schedule |
| burst_mode | input | 1 | 1: code-word bursts, 0: single pulses |
| code_word | input | WORD_BITS | Link code word, bit 0 sent first |
| pulse_out | output | 1 | Pulse strobe to the line driver |
| burst_done | output | 1 | One-cycle strobe at the end of a burst |

## Verification
The hardest case to reach from the ports is an enable drop in the middle of a pulse, followed by re-enable. It shows whether the pulse finishes at full width and whether the schedule truly rewinds. The bench waits for the rising edge of a data pulse, drops enable in that same cycle, and later re-enables. It then expects a clock pulse on the very next edge. Mid-burst changes to the code word and the mode are applied a few slots into a burst. The reference model captures values only at burst start, so any leak shows up as a cycle mismatch.

// File: rtl/flp_burst_gen.sv
module flp_burst_gen #(
  parameter longint unsigned CLK_HZ     = 25_000_000,
  parameter longint unsigned PULSE_NS   = 100,
  parameter longint unsigned SPACING_NS = 125_000,
  parameter longint unsigned DATA_NS    = 62_000,
  parameter longint unsigned PERIOD_NS  = 16_000_000,
  parameter int unsigned     WORD_BITS  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 burst_mode,
  input  logic [WORD_BITS-1:0] code_word,
  output logic                 pulse_out,
  output logic                 burst_done
);

  function automatic int unsigned ns2cyc(longint unsigned ns);
    longint unsigned c;
    c = (CLK_HZ * ns + 64'd500_000_000) / 64'd1_000_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  localparam int unsigned PW_C  = ns2cyc(PULSE_NS);
  localparam int unsigned SP_C  = ns2cyc(SPACING_NS);
  localparam int unsigned DO_C  = ns2cyc(DATA_NS);
  localparam int unsigned PER_C = ns2cyc(PERIOD_NS);
  localparam int unsigned NCLK  = WORD_BITS + 1;
  localparam int unsigned TW    = $clog2(PER_C);
  localparam int unsigned SW    = $clog2(SP_C);
  localparam int unsigned IW    = $clog2(NCLK + 1);
  localparam int unsigned PCW   = $clog2(PW_C + 1);

  logic [TW-1:0]        tick;
  logic [SW-1:0]        spos;
  logic [IW-1:0]        sidx;
  logic [PCW-1:0]       pcnt;
  logic [WORD_BITS-1:0] word_q, word_eff, word_sh;
  logic                 mode_q, mode_eff, run_q, last_q, done_q;
  logic                 go, at0, in_burst, clk_go, dat_go, sgl_go, start, final_go;

  wire [31:0] pulse_cyc = PW_C;

  assign go       = en && (run_q || pcnt == '0);
  assign at0      = go && tick == '0;
  assign mode_eff = at0 ? burst_mode : mode_q;
  assign word_eff = at0 ? code_word : word_q;
  assign word_sh  = word_eff >> sidx;
  assign in_burst = sidx < IW'(NCLK);
  assign clk_go   = go && mode_eff && in_burst && spos == '0;
  assign dat_go   = go && mode_eff && (sidx < IW'(NCLK - 1)) && spos == SW'(DO_C) && word_sh[0];
  assign sgl_go   = at0 && !burst_mode;
  assign start    = clk_go || dat_go || sgl_go;
  assign final_go = sgl_go || (clk_go && sidx == IW'(NCLK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
      spos <= '0;
      sidx <= '0;
    end else if (!go) begin
      tick <= '0;
      spos <= '0;
      sidx <= '0;
    end else if (tick == TW'(PER_C - 1)) begin
      tick <= '0;
      spos <= '0;
      sidx <= '0;
    end else begin
      tick <= tick + 1'b1;
      if (in_burst) begin
        if (spos == SW'(SP_C - 1)) begin
          spos <= '0;
          sidx <= sidx + 1'b1;
        end else begin
          spos <= spos + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= 1'b0;
      run_q  <= 1'b0;
      pcnt   <= '0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q <= go;
      if (at0) begin
        word_q <= code_word;
        mode_q <= burst_mode;
      end
      if (start) begin
        pcnt   <= PCW'(PW_C);
        last_q <= final_go;
      end else if (pcnt != '0) begin
        pcnt <= pcnt - 1'b1;
      end
      done_q <= (pcnt == PCW'(1)) && last_q && !start;
    end
  end

  assign pulse_out  = pcnt != '0;
  assign burst_done = done_q;

endmodule

module flp_burst_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        pulse_out,
  input logic        burst_done,
  input logic [31:0] pulse_cyc
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (pulse_out) run_len <= run_len + 1;
    else                run_len <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_out && run_len != 0) |-> run_len == pulse_cyc); // R2
  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> run_len < pulse_cyc); // R2
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $fell(pulse_out)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done); // R9
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pulse_out) |=> !pulse_out); // R8
endmodule

bind flp_burst_gen flp_burst_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .pulse_out(pulse_out),
  .burst_done(burst_done), .pulse_cyc(pulse_cyc)
);

// File: tb/flp_burst_gen_tb.sv
module flp_burst_gen_tb_top;
  localparam longint CLK_HZ = 100_000_000;
  localparam longint P_NS = 30, S_NS = 1250, D_NS = 620, T_NS = 80_000;

  function automatic int rnd(longint ns);
    longint c;
    c = (CLK_HZ * ns + 500_000_000) / 1_000_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  localparam int PW_E = rnd(P_NS);
  localparam int SP_E = rnd(S_NS);
  localparam int DO_E = rnd(D_NS);
  localparam int PER_E = rnd(T_NS);

  logic clk = 0, rst_n = 0, en = 0, burst_mode = 1;
  logic [15:0] code_word = '0;
  logic pulse_out, burst_done;

  flp_burst_gen #(.CLK_HZ(CLK_HZ), .PULSE_NS(P_NS), .SPACING_NS(S_NS),
                  .DATA_NS(D_NS), .PERIOD_NS(T_NS), .WORD_BITS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .burst_mode(burst_mode),
    .code_word(code_word), .pulse_out(pulse_out), .burst_done(burst_done));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R1";
  int starts[$], dones[$], rises[$], done_at[$];
  bit run_m = 0, exp_s = 0, exp_d = 0, prev_s = 0;
  int t_m = 0, last_rise = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference: schedule pulse start cycles into queues
  always @(posedge clk) begin
    int c;
    bit go;
    c = cyc;
    if (!rst_n) begin
      starts.delete(); dones.delete();
      run_m = 0; t_m = 0; exp_s = 0; exp_d = 0;
    end else begin
      go = en && (run_m || !exp_s);
      if (!go) begin
        starts = starts.find(x) with (x < c);
        dones = dones.find(x) with (x < c + PW_E);
        run_m = 0;
      end else begin
        if (!run_m) t_m = 0;
        if (t_m == 0) begin
          if (burst_mode) begin
            for (int k = 0; k <= 16; k++) starts.push_back(c + k * SP_E);
            for (int k = 0; k < 16; k++)
              if (code_word[k]) starts.push_back(c + k * SP_E + DO_E);
            dones.push_back(c + 16 * SP_E + PW_E);
          end else begin
            starts.push_back(c);
            dones.push_back(c + PW_E);
          end
        end
        run_m = 1;
        t_m = (t_m + 1) % PER_E;
      end
      starts = starts.find(x) with (x + PW_E > c);
      dones = dones.find(x) with (x >= c);
      exp_s = 0;
      foreach (starts[i]) if (starts[i] <= c) exp_s = 1;
      exp_d = 0;
      foreach (dones[i]) if (dones[i] == c) exp_d = 1;
    end
    cyc++;
    if (cyc > 190_000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190_000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    chk(pulse_out == exp_s, cur_tag, "pulse_out per cycle", pulse_out, exp_s);
    chk(burst_done == exp_d, "R9", "burst_done per cycle", burst_done, exp_d);
    if (pulse_out && !prev_s) begin
      rises.push_back(cyc - 1);
      last_rise = cyc - 1;
    end
    if (!pulse_out && prev_s)
      chk((cyc - 1 - last_rise) == PW_E, "R2", "pulse width", cyc - 1 - last_rise, PW_E);
    if (burst_done) done_at.push_back(cyc - 1);
    prev_s = pulse_out;
  end

  function automatic bit has_rise(int c);
    foreach (rises[i]) if (rises[i] == c) return 1;
    return 0;
  endfunction

  function automatic int count_in(int lo, int hi);
    int n = 0;
    foreach (rises[i]) if (rises[i] >= lo && rises[i] < hi) n++;
    return n;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0, c_en;
    logic [15:0] w;
    wait_cyc(4);
    chk(pulse_out == 0, "R1", "pulse_out in reset", pulse_out, 0);
    chk(burst_done == 0, "R1", "burst_done in reset", burst_done, 0);
    rst_n = 1;
    wait_cyc(3);
    chk(pulse_out == 0, "R1", "pulse_out after reset", pulse_out, 0);

    // scenario A: mixed word
    cur_tag = "R3";
    w = 16'hA5C3;
    rises.delete(); done_at.delete();
    code_word = w; burst_mode = 1; en = 1;
    wait_cyc(PER_E + 10);
    r0 = rises[0];
    for (int k = 0; k <= 16; k++)
      chk(has_rise(r0 + k * SP_E), "R3", "clock pulse present", k, 1);
    for (int k = 0; k < 16; k++)
      chk(has_rise(r0 + k * SP_E + DO_E) == w[k], "R4", "data pulse by bit", has_rise(r0 + k * SP_E + DO_E), w[k]);
    chk(count_in(r0, r0 + PER_E) == 17 + $countones(w), "R4", "pulses per burst", count_in(r0, r0 + PER_E), 17 + $countones(w));
    chk(has_rise(r0 + PER_E), "R5", "next burst start", has_rise(r0 + PER_E), 1);
    chk(rises[1] - r0 == rnd(D_NS), "R10", "data offset cycles", rises[1] - r0, rnd(D_NS));
    chk(SP_E == 125 && PW_E == 3, "R10", "derived spacing", SP_E, 125);
    chk(done_at.size() > 0 && done_at[0] == r0 + 16 * SP_E + PW_E, "R9", "burst_done cycle", done_at.size() > 0 ? done_at[0] : -1, r0 + 16 * SP_E + PW_E);

    // scenario B: mid-burst changes, single mode, all-ones word
    en = 0;
    wait_cyc(20);
    cur_tag = "R7";
    rises.delete();
    code_word = 16'h0000; burst_mode = 1; en = 1;
    wait_cyc(300);
    r0 = rises[0];
    code_word = 16'hFFFF; burst_mode = 0;
    wait_cyc(PER_E);
    cur_tag = "R6";
    burst_mode = 1;
    wait_cyc(2 * PER_E);
    chk(count_in(r0, r0 + PER_E) == 17, "R7", "burst unaffected by change", count_in(r0, r0 + PER_E), 17);
    chk(count_in(r0 + PER_E, r0 + 2 * PER_E) == 1, "R6", "single pulse count", count_in(r0 + PER_E, r0 + 2 * PER_E), 1);
    chk(has_rise(r0 + PER_E), "R6", "single pulse position", has_rise(r0 + PER_E), 1);
    chk(count_in(r0 + 2 * PER_E, r0 + 3 * PER_E) == 33, "R4", "all-ones burst count", count_in(r0 + 2 * PER_E, r0 + 3 * PER_E), 33);

    // scenario C: disable at the rise of a data pulse, then re-enable
    en = 0;
    wait_cyc(20);
    cur_tag = "R8";
    rises.delete();
    code_word = 16'h0001; burst_mode = 1; en = 1;
    wait (rises.size() == 2);
    @(negedge clk);
    en = 0;
    wait_cyc(1000);
    chk(rises.size() == 2, "R8", "no pulses after disable", rises.size(), 2);
    chk(pulse_out == 0, "R8", "output held low", pulse_out, 0);
    c_en = cyc;
    en = 1;
    wait_cyc(10);
    chk(rises.size() == 3 && rises[2] == c_en, "R8", "restart on first enabled cycle", rises.size() == 3 ? rises[2] : -1, c_en);
    wait_cyc(PER_E + 100);
    en = 0;
    wait_cyc(50);
    finish_run();
  end
endmodule